// File: doc/BRIEF.md
# Decode-Stage Branch Resolution and Link Unit

This unit is combinational. It sits in the decode stage of a 32-bit, five-stage, in-order pipeline that has one architectural delay slot. Its inputs are the instruction word, the instruction's PC and the two register operands already read from the register file. From these it resolves every jump and branch in decode:

- whether control transfers, and where to;
- for the linking forms, the return address (PC+8), the destination register and the write enable;
- which operands the instruction needs.

When a transfer is taken, the unit marks the following instruction as a delay-slot occupant. It also forwards the flag that says whether the current instruction is itself in a delay slot.

Instructions that are not jumps or branches leave every output inactive. While the active-low reset is asserted, every output is held at zero. The clock input exists only so that the embedded checks have a sampling point; no output depends on it.

Top module: `br_resolve_unit`

## Requirements
- R1: Only these codes are recognised as transfers. Primary opcode (bits 31:26): 000010 J, 000011 JAL, 000100 BEQ, 000101 BNE, 000110 BLEZ, 000111 BGTZ. Under primary 000000, function code (bits 5:0) 001000 JR and 001001 JALR. Under primary 000001, rt field (bits 20:16) 00000 BLTZ, 00001 BGEZ, 10000 BLTZAL, 10001 BGEZAL. Every other encoding gives zero on all outputs except `cur_in_slot_o`.
- R2: J and JAL are always taken. Their target is bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R3: JR and JALR are always taken, to the value of operand A. They are recognised only when bits 10:6 are zero.
- R4: A taken conditional branch targets PC+4 plus the sign-extended 16-bit offset (bits 15:0) multiplied by 4, computed modulo 2^32.
- R5: BEQ is taken when A equals B. BNE is taken when A differs from B.
- R6: With A read as a signed 32-bit value, the branches are taken as follows: BGTZ when A > 0, BLEZ when A <= 0, BGEZ and BGEZAL when A >= 0, BLTZ and BLTZAL when A < 0.
- R7: JAL, JALR, BGEZAL and BLTZAL raise `link_we_o` and give a link address of PC+8. The destination is register 31, except for JALR, whose destination is bits 15:11. Other instructions give a zero link address and a zero destination.
- R8: BGEZAL and BLTZAL raise `link_we_o` and give the PC+8 link address whether or not the branch is taken.
- R9: `take_o` and `next_in_slot_o` are always equal. When no transfer is taken, `target_o` is zero.
- R10: Out of reset, `cur_in_slot_o` equals `cur_in_slot_i`.
- R11: While `rst_n` is low, all outputs are zero.
- R12: `rd_a_o` is set for JR, JALR, BLEZ, BGTZ and the four rt-group branches. `rd_a_o` and `rd_b_o` are both set for BEQ and BNE. Neither is set for J, JAL or any other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the embedded checks only |
| rst_n | input | 1 | Active-low reset; forces all outputs to zero |
| instr | input | 32 | Instruction word in decode |
| pc | input | 32 | Address of that instruction |
| opa | input | 32 | Register operand A (rs) |
| opb | input | 32 | Register operand B (rt) |
| cur_in_slot_i | input | 1 | Current instruction occupies a delay slot |
| take_o | output | 1 | Control transfer taken |
| target_o | output | 32 | Transfer target, zero when not taken |
| link_addr_o | output | 32 | Return address (PC+8) for linking forms |
| link_we_o | output | 1 | Write enable for the link register |
| link_dst_o | output | 5 | Link destination register index |
| next_in_slot_o | output | 1 | Next instruction will occupy a delay slot |
| cur_in_slot_o | output | 1 | Forwarded delay-slot flag |
| rd_a_o | output | 1 | Operand A is needed |
| rd_b_o | output | 1 | Operand B is needed |

## Verification
Every result is due in the same cycle as its inputs, with no register delay, because there is no register between any input and any output. The bench changes inputs on the falling clock edge and compares outputs 2 ns later, well before the next rising edge. The embedded checks therefore sample settled values at that rising edge. The sweeps cover every primary opcode, every special function code, every rt code, and each condition at 0, -1, 1 and both 32-bit extremes.

// File: rtl/br_pkg.sv
// Package br_pkg
// Shared encodings and the decoded-instruction record for the branch
// resolution unit. Assumes the 32-bit fixed instruction layout.
package br_pkg;

    localparam logic [5:0] OP_SPECIAL = 6'b000000;
    localparam logic [5:0] OP_REGIMM  = 6'b000001;
    localparam logic [5:0] OP_J       = 6'b000010;
    localparam logic [5:0] OP_JAL     = 6'b000011;
    localparam logic [5:0] OP_BEQ     = 6'b000100;
    localparam logic [5:0] OP_BNE     = 6'b000101;
    localparam logic [5:0] OP_BLEZ    = 6'b000110;
    localparam logic [5:0] OP_BGTZ    = 6'b000111;
    localparam logic [5:0] FN_JR      = 6'b001000;
    localparam logic [5:0] FN_JALR    = 6'b001001;
    localparam logic [4:0] RT_BLTZ    = 5'b00000;
    localparam logic [4:0] RT_BGEZ    = 5'b00001;
    localparam logic [4:0] RT_BLTZAL  = 5'b10000;
    localparam logic [4:0] RT_BGEZAL  = 5'b10001;

    typedef enum logic [3:0] {
        BK_NONE, BK_J, BK_JAL, BK_JR, BK_JALR, BK_BEQ, BK_BNE,
        BK_BLEZ, BK_BGTZ, BK_BLTZ, BK_BGEZ, BK_BLTZAL, BK_BGEZAL
    } br_kind_e;

    typedef struct packed {
        br_kind_e   kind;
        logic       rd_a;
        logic       rd_b;
        logic       links;
        logic [4:0] dst;
    } br_dec_t;

endpackage

// File: rtl/br_classify.sv
// Module br_classify
// Maps opcode, function and rt fields to a transfer kind, operand read
// requests and link destination. Assumes REGW-bit register indices.
module br_classify
    import br_pkg::*;
#(
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  op,
    input  logic [20:0] low_bits,
    output br_dec_t     dec
);
    localparam logic [REGW-1:0] LINK_IDX = REGW'(LINK_REG);

    logic [5:0]      fn;
    logic [4:0]      sh;
    logic [4:0]      rt;
    logic [REGW-1:0] rd;

    assign fn = low_bits[5:0];
    assign sh = low_bits[10:6];
    assign rd = low_bits[15:11];
    assign rt = low_bits[20:16];

    // Decode the instruction fields into one transfer record.
    always_comb begin
        dec = '{kind: BK_NONE, rd_a: 1'b0, rd_b: 1'b0, links: 1'b0, dst: '0};
        unique case (op)
            OP_J:    dec.kind = BK_J;
            OP_JAL:  begin dec.kind = BK_JAL; dec.links = 1'b1; dec.dst = LINK_IDX; end
            OP_BEQ:  begin dec.kind = BK_BEQ;  dec.rd_a = 1'b1; dec.rd_b = 1'b1; end
            OP_BNE:  begin dec.kind = BK_BNE;  dec.rd_a = 1'b1; dec.rd_b = 1'b1; end
            OP_BLEZ: begin dec.kind = BK_BLEZ; dec.rd_a = 1'b1; end
            OP_BGTZ: begin dec.kind = BK_BGTZ; dec.rd_a = 1'b1; end
            OP_SPECIAL: begin
                if (sh == 5'd0 && fn == FN_JR) begin
                    dec.kind = BK_JR;
                    dec.rd_a = 1'b1;
                end else if (sh == 5'd0 && fn == FN_JALR) begin
                    dec.kind  = BK_JALR;
                    dec.rd_a  = 1'b1;
                    dec.links = 1'b1;
                    dec.dst   = rd;
                end
            end
            OP_REGIMM: begin
                unique case (rt)
                    RT_BLTZ:   begin dec.kind = BK_BLTZ; dec.rd_a = 1'b1; end
                    RT_BGEZ:   begin dec.kind = BK_BGEZ; dec.rd_a = 1'b1; end
                    RT_BLTZAL: begin
                        dec.kind = BK_BLTZAL; dec.rd_a = 1'b1;
                        dec.links = 1'b1; dec.dst = LINK_IDX;
                    end
                    RT_BGEZAL: begin
                        dec.kind = BK_BGEZAL; dec.rd_a = 1'b1;
                        dec.links = 1'b1; dec.dst = LINK_IDX;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    AST_ABS_JUMP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == BK_J || dec.kind == BK_JAL) |-> (!dec.rd_a && !dec.rd_b)); // R12
    AST_NONE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == BK_NONE) |-> (!dec.rd_a && !dec.links)); // R1

endmodule

// File: rtl/br_condition.sv
// Module br_condition
// Evaluates whether the decoded transfer is taken, from the operand
// values. Assumes two's-complement XLEN-bit operands.
module br_condition
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  br_kind_e        kind,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            taken
);
    logic a_neg;
    logic a_zero;
    logic a_eq_b;

    assign a_neg  = opa[XLEN-1];
    assign a_zero = (opa == '0);
    assign a_eq_b = (opa == opb);

    // Select the condition belonging to each transfer kind.
    always_comb begin
        unique case (kind)
            BK_J, BK_JAL, BK_JR, BK_JALR: taken = 1'b1;
            BK_BEQ:                       taken = a_eq_b;
            BK_BNE:                       taken = !a_eq_b;
            BK_BGTZ:                      taken = !a_neg && !a_zero;
            BK_BLEZ:                      taken = a_neg || a_zero;
            BK_BGEZ, BK_BGEZAL:           taken = !a_neg;
            BK_BLTZ, BK_BLTZAL:           taken = a_neg;
            default:                      taken = 1'b0;
        endcase
    end

    AST_REG_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_JR || kind == BK_JALR) |-> taken); // R3
    AST_NONE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_NONE) |-> !taken); // R1

endmodule

// File: rtl/br_address.sv
// Module br_address
// Forms the raw transfer target for each kind and the PC+8 return
// address. Assumes word-aligned instructions in XLEN-bit space.
module br_address
    import br_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  br_kind_e        kind,
    input  logic [25:0]     idx26,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] target_raw,
    output logic [XLEN-1:0] ret_addr
);
    localparam int SEXT_W = XLEN - 18;

    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] rel_off;
    logic [XLEN-1:0] abs_tgt;

    assign pc_next  = pc + XLEN'(4);
    assign ret_addr = pc + XLEN'(8);
    assign rel_off  = {{SEXT_W{idx26[15]}}, idx26[15:0], 2'b00};
    assign abs_tgt  = {pc_next[XLEN-1:28], idx26, 2'b00};

    // Choose the address form that matches the transfer kind.
    always_comb begin
        unique case (kind)
            BK_J, BK_JAL:    target_raw = abs_tgt;
            BK_JR, BK_JALR:  target_raw = opa;
            BK_NONE:         target_raw = '0;
            default:         target_raw = pc_next + rel_off;
        endcase
    end

endmodule

// File: rtl/br_resolve_unit.sv
// Module br_resolve_unit
// Decode-stage jump/branch resolver with link generation and delay-slot
// flags. Purely combinational; clk only samples the embedded checks.
// Assumes operands are already read and forwarded by the pipeline.
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            cur_in_slot_i,
    output logic            take_o,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] link_addr_o,
    output logic            link_we_o,
    output logic [REGW-1:0] link_dst_o,
    output logic            next_in_slot_o,
    output logic            cur_in_slot_o,
    output logic            rd_a_o,
    output logic            rd_b_o
);
    br_dec_t         dec;
    logic            taken_raw;
    logic [XLEN-1:0] target_raw;
    logic [XLEN-1:0] ret_addr;

    br_classify #(.REGW(REGW), .LINK_REG(LINK_REG)) u_classify (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (instr[31:26]),
        .low_bits (instr[20:0]),
        .dec      (dec)
    );

    br_condition #(.XLEN(XLEN)) u_condition (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (dec.kind),
        .opa   (opa),
        .opb   (opb),
        .taken (taken_raw)
    );

    br_address #(.XLEN(XLEN)) u_address (
        .kind       (dec.kind),
        .idx26      (instr[25:0]),
        .pc         (pc),
        .opa        (opa),
        .target_raw (target_raw),
        .ret_addr   (ret_addr)
    );

    // Gate every result with reset and with the taken/link decisions.
    always_comb begin
        take_o         = rst_n && taken_raw;
        next_in_slot_o = take_o;
        target_o       = take_o ? target_raw : '0;
        link_we_o      = rst_n && dec.links;
        link_addr_o    = link_we_o ? ret_addr : '0;
        link_dst_o     = link_we_o ? dec.dst : '0;
        rd_a_o         = rst_n && dec.rd_a;
        rd_b_o         = rst_n && dec.rd_b;
        cur_in_slot_o  = rst_n && cur_in_slot_i;
    end

    AST_IDLE_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (target_o == '0)); // R9
    AST_LINK_IS_PC8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_addr_o == pc + XLEN'(8))); // R7
    AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cur_in_slot_o == cur_in_slot_i); // R10
    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_o |-> rd_a_o); // R12

    // Check that reset silences every output.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_SILENT: assert (!take_o && !next_in_slot_o && !link_we_o &&
                target_o == '0 && link_addr_o == '0 && !cur_in_slot_o); // R11
        end
    end

endmodule

// File: tb/test_br_resolve_unit.sv
// Bench for br_resolve_unit: sweeps opcodes and boundary operand values
// against an arithmetic model built from the requirements.
module test_br_resolve_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0, pc = '0, opa = '0, opb = '0;
    logic        cur_in_slot_i = 1'b0;
    logic        take_o, link_we_o, next_in_slot_o, cur_in_slot_o, rd_a_o, rd_b_o;
    logic [31:0] target_o, link_addr_o;
    logic [4:0]  link_dst_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    br_resolve_unit i_br_resolve_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc), .opa(opa), .opb(opb),
        .cur_in_slot_i(cur_in_slot_i), .take_o(take_o), .target_o(target_o),
        .link_addr_o(link_addr_o), .link_we_o(link_we_o), .link_dst_o(link_dst_o),
        .next_in_slot_o(next_in_slot_o), .cur_in_slot_o(cur_in_slot_o),
        .rd_a_o(rd_a_o), .rd_b_o(rd_b_o)
    );

    // Bundle layout: take, target, link addr, link we, dst, next, cur, rda, rdb
    function automatic logic [74:0] model(input logic [31:0] ins, input logic [31:0] p,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic cur, input logic rst);
        logic [5:0]  op  = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  rt  = ins[20:16];
        logic [4:0]  sh  = ins[10:6];
        int signed   sa  = $signed(a);
        int signed   off = $signed(ins[15:0]);
        logic [31:0] rel = p + 32'd4 + 32'(off * 4);
        logic [31:0] jt  = ((p + 32'd4) & 32'hF000_0000) | {4'h0, ins[25:0], 2'b00};
        logic tk = 0, lk = 0, ra = 0, rb = 0;
        logic [31:0] t = 0;
        logic [4:0] d = 0;
        if (!rst) return '0;
        case (op)
            6'd2: begin tk = 1; t = jt; end
            6'd3: begin tk = 1; t = jt; lk = 1; d = 5'd31; end
            6'd4: begin ra = 1; rb = 1; tk = (a == b); t = rel; end
            6'd5: begin ra = 1; rb = 1; tk = (a != b); t = rel; end
            6'd6: begin ra = 1; tk = (sa <= 0); t = rel; end
            6'd7: begin ra = 1; tk = (sa > 0); t = rel; end
            6'd0: if (sh == 0 && (fn == 6'd8 || fn == 6'd9)) begin
                ra = 1; tk = 1; t = a;
                if (fn == 6'd9) begin lk = 1; d = ins[15:11]; end
            end
            6'd1: if (rt == 0 || rt == 1 || rt == 16 || rt == 17) begin
                ra = 1; t = rel;
                tk = rt[0] ? (sa >= 0) : (sa < 0);
                if (rt[4]) begin lk = 1; d = 5'd31; end
            end
            default: ;
        endcase
        return {tk, tk ? t : 32'd0, lk ? p + 32'd8 : 32'd0, lk, d, tk, cur, ra, rb};
    endfunction

    task automatic apply(input string tag, input logic [31:0] ins, input logic [31:0] p,
                         input logic [31:0] a, input logic [31:0] b, input logic cur);
        logic [74:0] got, exp;
        @(negedge clk);
        instr = ins; pc = p; opa = a; opb = b; cur_in_slot_i = cur;
        #2;
        got = {take_o, target_o, link_addr_o, link_we_o, link_dst_o,
               next_in_slot_o, cur_in_slot_o, rd_a_o, rd_b_o};
        exp = model(ins, p, a, b, cur, rst_n);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s instr=%h a=%h b=%h actual=%h expected=%h",
                     tag, ins, a, b, got, exp);
        end
    endtask

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h2, 32'hFFFF_FFFE, 32'h1234_5678};
    logic [15:0] offs [4] = '{16'h0003, 16'h7FFF, 16'h8000, 16'hFFFF};
    logic [31:0] pcs  [3] = '{32'h0040_0100, 32'hFFFF_FFF0, 32'h7FFF_FFFC};

    initial begin
        // R11: reset silences everything, even a linking jump in a slot
        apply("R11", {6'd3, 26'h3FF_FFFF}, 32'h1000_0000, 32'h5, 32'h5, 1'b1);
        apply("R11", {6'd1, 5'd3, 5'd17, 16'h8000}, 32'h0, 32'h0, 32'h0, 1'b1);
        @(negedge clk); rst_n = 1'b1;

        // R1: every primary opcode with assorted fields
        for (int o = 0; o < 64; o++)
            apply("R1", {o[5:0], 26'h2A5_5A5A}, 32'h0040_0000, 32'h10, 32'h10, o[0]);
        // R1 R3: every special function code, zero and nonzero bits 10:6
        for (int f = 0; f < 64; f++) begin
            apply("R1 R3", {6'd0, 5'd4, 5'd0, 5'd9, 5'd0, f[5:0]}, 32'h100, 32'hABCD_0000, 32'h0, 1'b0);
            apply("R1 R3", {6'd0, 5'd4, 5'd0, 5'd9, 5'd1, f[5:0]}, 32'h100, 32'hABCD_0000, 32'h0, 1'b0);
        end
        // R1 R12: every rt code in the register-immediate group
        for (int r = 0; r < 32; r++) begin
            apply("R1 R12", {6'd1, 5'd2, r[4:0], 16'h0010}, 32'h200, 32'h8000_0000, 32'h0, 1'b0);
            apply("R1 R12", {6'd1, 5'd2, r[4:0], 16'h0010}, 32'h200, 32'h0, 32'h0, 1'b1);
        end
        // R2 R7: absolute jumps across PC regions
        for (int p = 0; p < 3; p++) begin
            apply("R2", {6'd2, 26'h155_5555}, pcs[p], 32'h0, 32'h0, 1'b0);
            apply("R2 R7", {6'd3, 26'h2AA_AAAA}, pcs[p], 32'h0, 32'h0, 1'b0);
        end
        apply("R2", {6'd2, 26'h0}, 32'hEFFF_FFFC, 32'h0, 32'h0, 1'b0); // PC+4 crosses region
        // R3 R7: register jumps, various destinations
        for (int v = 0; v < 8; v++) begin
            apply("R3", {6'd0, 5'd3, 5'd0, 5'd0, 5'd0, 6'd8}, 32'h300, vals[v], 32'h0, 1'b0);
            apply("R3 R7", {6'd0, 5'd3, 5'd0, v[4:0] + 5'd7, 5'd0, 6'd9}, 32'h300, vals[v], 32'h0, 1'b1);
        end
        // R5 R4: equality branches over all operand pairs and offsets
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                apply("R5 R4", {6'd4, 5'd1, 5'd2, offs[(i + j) % 4]}, pcs[i % 3], vals[i], vals[j], 1'b0);
                apply("R5 R4", {6'd5, 5'd1, 5'd2, offs[i % 4]}, pcs[j % 3], vals[i], vals[j], 1'b0);
            end
        // R6 R8 R4 R9: sign-tested branches at boundary values
        for (int v = 0; v < 8; v++)
            for (int k = 0; k < 4; k++) begin
                apply("R6 R4 R9", {6'd6, 5'd1, 5'd0, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b0);
                apply("R6 R4 R9", {6'd7, 5'd1, 5'd0, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b0);
                apply("R6 R9", {6'd1, 5'd1, 5'd0, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b0);
                apply("R6 R9", {6'd1, 5'd1, 5'd1, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b0);
                apply("R6 R8", {6'd1, 5'd1, 5'd16, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b1);
                apply("R6 R8", {6'd1, 5'd1, 5'd17, offs[k]}, pcs[k % 3], vals[v], 32'h0, 1'b1);
            end
        // R10: slot flag passes through on a non-transfer instruction
        apply("R10", 32'h0000_0020, 32'h0, 32'h0, 32'h0, 1'b1);
        apply("R10", 32'h0000_0020, 32'h0, 32'h0, 32'h0, 1'b0);
        // R11: reset re-asserted mid-run
        @(negedge clk); rst_n = 1'b0;
        apply("R11", {6'd4, 5'd1, 5'd2, 16'h0004}, 32'h400, 32'h9, 32'h9, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_errors++;
                n_checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule